// File: doc/BRIEF.md
# Host Port Selection and Lock Controller

This block decides whether a device's host interface is served by the I2C engine or by the SPI engine, which share one chip-select pin. After reset the device listens as an I2C target. A host that wants SPI toggles the shared chip-select pin three times while the choice is still open, and the block moves the device to SPI. Software then fixes the choice for good through a configuration-register write. While I2C is active, a write that sets the lock bit fixes I2C. While SPI is active, any write to that register fixes SPI, whatever the data. A fixed choice holds through power-mode changes and is released only by a hardware reset.

The chip-select pin is asynchronous to the block clock. It passes through a synchronizer and then an edge detector. One toggle is two consecutive edges, high-low-high or low-high-low. A power-mode change while the choice is still open sends the device back to I2C and discards any toggles counted so far.

The controller has four states. `PS_I2C_OPEN` is the reset state. `PS_SPI_OPEN` is reached from it on the third toggle (transition *switch*). `PS_I2C_HELD` is reached from `PS_I2C_OPEN` by a write with the lock bit set (transition *lock-i2c*). `PS_SPI_HELD` is reached from `PS_SPI_OPEN` by any write (transition *lock-spi*). A power-mode change takes `PS_SPI_OPEN` back to `PS_I2C_OPEN` (transition *fallback*). Both held states keep their state until reset.

Top module: `serport_lock_ctrl`

## Requirements
- R1: After reset, `spi_active` is 0 (I2C) and `port_locked` is 0.
- R2: In the open I2C state, three complete toggles of `cs_pin` set `spi_active` to 1, with `port_locked` staying 0.
- R3: A toggle counts only when both of its edges have arrived. After five edges (two and a half toggles) the port is still I2C. The sixth edge switches it to SPI.
- R4: In the open I2C state, a pulse on `cfg_wr` with `cfg_lock_bit`=1 sets `port_locked` to 1 and keeps `spi_active` at 0. A pulse with `cfg_lock_bit`=0 changes neither output.
- R5: While I2C is locked, any number of toggles on `cs_pin` leaves `spi_active` at 0.
- R6: In the open SPI state, a pulse on `cfg_wr` sets `port_locked` to 1 and keeps `spi_active` at 1, for either value of `cfg_lock_bit`.
- R7: While SPI is locked, no stimulus on `cs_pin`, `cfg_wr`, `cfg_lock_bit` or `pwr_mode_chg` clears `spi_active`.
- R8: A pulse on `pwr_mode_chg` leaves both outputs unchanged while `port_locked` is 1.
- R9: A pulse on `pwr_mode_chg` while `port_locked` is 0 returns `spi_active` to 0 and discards a partial toggle count. Three fresh toggles are then needed to reach SPI.
- R10: Once set, `port_locked` stays at 1 until `rst_n` is asserted. Asserting `rst_n` restores the R1 state.
- R11: When `cfg_wr` and `pwr_mode_chg` arrive in the same cycle in an open state, the write wins. The port locks in the mode that was active before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cs_pin | input | 1 | Shared chip-select pin level, asynchronous, idle high |
| cfg_wr | input | 1 | One-cycle strobe: write to the configuration register |
| cfg_lock_bit | input | 1 | Lock bit of the data carried by that write |
| pwr_mode_chg | input | 1 | One-cycle pulse on a power-mode change |
| spi_active | output | 1 | 1 = SPI engine owns the host port, 0 = I2C |
| port_locked | output | 1 | 1 = port choice is fixed until reset |

## Verification
The bench stops after five edges to catch a design that counts single edges as toggles, which would switch to SPI too early. It also counts to exactly three toggles to catch a miscounted threshold. It applies toggles and power-mode pulses to each locked state, which would expose a lock that leaks, for example SPI falling back to I2C or I2C jumping to SPI. It writes a zero lock bit in I2C and a zero data word in SPI, to catch a design that uses the same lock rule for both ports. It applies a write and a power-mode change in the same cycle to check their priority, and it checks that a power-mode change clears a partial toggle count.

// File: rtl/serport_lock_pkg.sv
package serport_lock_pkg;

    // Port-selection controller states
    typedef enum logic [1:0] {
        PS_I2C_OPEN = 2'b00,
        PS_I2C_HELD = 2'b01,
        PS_SPI_OPEN = 2'b10,
        PS_SPI_HELD = 2'b11
    } port_state_e;

endpackage

// File: rtl/serport_pin_sync.sv
// Multi-flop synchronizer followed by a one-flop edge detector.
module serport_pin_sync #(
    parameter int STAGES    = 2,
    parameter bit IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_edge
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= IDLE_LEVEL;
                    else        sync_q[0] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[gi] <= IDLE_LEVEL;
                    else        sync_q[gi] <= sync_q[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE_LEVEL;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign pin_edge = sync_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/serport_toggle_count.sv
// Counts synchronized edges; two edges form one toggle.
module serport_toggle_count #(
    parameter int TOGGLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic count_clr,
    input  logic pin_edge,
    output logic reached
);

    localparam int EDGE_TGT = 2 * TOGGLES;
    localparam int CW       = $clog2(EDGE_TGT + 1);

    logic [CW-1:0] edge_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt_q <= '0;
        end else if (count_clr) begin
            edge_cnt_q <= '0;
        end else if (count_en && pin_edge) begin
            edge_cnt_q <= edge_cnt_q + 1'b1;
        end
    end

    assign reached = count_en && !count_clr && pin_edge &&
                     (edge_cnt_q == CW'(EDGE_TGT - 1));

endmodule

// File: rtl/serport_sel_fsm.sv
// Port-selection state machine.
module serport_sel_fsm
    import serport_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic toggles_done,
    input  logic cfg_wr,
    input  logic cfg_lock_bit,
    input  logic pwr_mode_chg,
    output logic count_en,
    output logic count_clr,
    output logic spi_active,
    output logic port_locked
);

    port_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_I2C_OPEN: begin
                if (cfg_wr && cfg_lock_bit) state_d = PS_I2C_HELD;   // lock-i2c
                else if (pwr_mode_chg)      state_d = PS_I2C_OPEN;
                else if (toggles_done)      state_d = PS_SPI_OPEN;   // switch
            end
            PS_SPI_OPEN: begin
                if (cfg_wr)                 state_d = PS_SPI_HELD;   // lock-spi
                else if (pwr_mode_chg)      state_d = PS_I2C_OPEN;   // fallback
            end
            PS_I2C_HELD:                    state_d = PS_I2C_HELD;
            PS_SPI_HELD:                    state_d = PS_SPI_HELD;
            default:                        state_d = PS_I2C_OPEN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_I2C_OPEN;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        count_en    = 1'b0;
        count_clr   = 1'b1;
        spi_active  = 1'b0;
        port_locked = 1'b0;
        unique case (state_q)
            PS_I2C_OPEN: begin
                count_en  = 1'b1;
                count_clr = pwr_mode_chg;
            end
            PS_SPI_OPEN: spi_active = 1'b1;
            PS_I2C_HELD: port_locked = 1'b1;
            PS_SPI_HELD: begin
                spi_active  = 1'b1;
                port_locked = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/serport_lock_ctrl.sv
module serport_lock_ctrl #(
    parameter int SYNC_STAGES    = 2,
    parameter int TOGGLES_TO_SPI = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_pin,
    input  logic cfg_wr,
    input  logic cfg_lock_bit,
    input  logic pwr_mode_chg,
    output logic spi_active,
    output logic port_locked
);

    logic pin_edge;
    logic toggles_done;
    logic count_en;
    logic count_clr;

    serport_pin_sync #(
        .STAGES     (SYNC_STAGES),
        .IDLE_LEVEL (1'b1)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (cs_pin),
        .pin_edge  (pin_edge)
    );

    serport_toggle_count #(
        .TOGGLES (TOGGLES_TO_SPI)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (count_en),
        .count_clr (count_clr),
        .pin_edge  (pin_edge),
        .reached   (toggles_done)
    );

    serport_sel_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .toggles_done (toggles_done),
        .cfg_wr       (cfg_wr),
        .cfg_lock_bit (cfg_lock_bit),
        .pwr_mode_chg (pwr_mode_chg),
        .count_en     (count_en),
        .count_clr    (count_clr),
        .spi_active   (spi_active),
        .port_locked  (port_locked)
    );

endmodule

// File: rtl/serport_lock_chk.sv
module serport_lock_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic cfg_lock_bit,
    input logic pwr_mode_chg,
    input logic spi_active,
    input logic port_locked
);

    // R10: a lock never drops without reset
    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        port_locked |=> port_locked);

    // R5, R7: a locked port never changes mode
    assert_locked_mode_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        port_locked |=> $stable(spi_active));

    // R2: the switch to SPI only happens while unlocked
    assert_switch_when_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_active) |-> !$past(port_locked));

    // R4: lock-bit write in open I2C locks I2C
    assert_i2c_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_locked && !spi_active && cfg_wr && cfg_lock_bit) |=> (port_locked && !spi_active));

    // R6, R11: any write in open SPI locks SPI
    assert_spi_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_locked && spi_active && cfg_wr) |=> (port_locked && spi_active));

    // R9: power-mode change while open falls back to I2C
    assert_open_fallback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_locked && pwr_mode_chg && !cfg_wr) |=> (!spi_active && !port_locked));

    // R8: locked outputs unaffected by a power-mode change
    assert_pwr_keeps_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (port_locked && pwr_mode_chg) |=> (port_locked && $stable(spi_active)));

endmodule

bind serport_lock_ctrl serport_lock_chk u_lock_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_lock_bit (cfg_lock_bit),
    .pwr_mode_chg (pwr_mode_chg),
    .spi_active   (spi_active),
    .port_locked  (port_locked)
);

// File: tb/tb_serport_lock_ctrl.sv
`timescale 1ns/1ps
module tb_serport_lock_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_pin = 1'b1;
    logic cfg_wr = 1'b0;
    logic cfg_lock_bit = 1'b0;
    logic pwr_mode_chg = 1'b0;
    logic spi_active;
    logic port_locked;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    serport_lock_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_pin       (cs_pin),
        .cfg_wr       (cfg_wr),
        .cfg_lock_bit (cfg_lock_bit),
        .pwr_mode_chg (pwr_mode_chg),
        .spi_active   (spi_active),
        .port_locked  (port_locked)
    );

    // exp = {spi_active, port_locked}
    task automatic check(input string req, input logic [1:0] exp);
        n_checks++;
        if ({spi_active, port_locked} !== exp) begin
            n_fails++;
            $display("FAIL %s: got spi=%b lock=%b expected spi=%b lock=%b",
                     req, spi_active, port_locked, exp[1], exp[0]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs_pin = 1'b1; cfg_wr = 1'b0;
        cfg_lock_bit = 1'b0; pwr_mode_chg = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic pin_edges(input int n);
        for (int i = 0; i < n; i++) begin
            cs_pin = ~cs_pin;
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic cfg_write(input logic lock_bit, input logic with_pwr);
        cfg_wr = 1'b1; cfg_lock_bit = lock_bit; pwr_mode_chg = with_pwr;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_lock_bit = 1'b0; pwr_mode_chg = 1'b0;
        @(negedge clk);
    endtask

    task automatic pwr_pulse();
        pwr_mode_chg = 1'b1;
        @(negedge clk);
        pwr_mode_chg = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 reset state", 2'b00);
    endtask

    task automatic t_toggle_switch();
        do_reset();
        pin_edges(5);
        check("R3 five edges stay I2C", 2'b00);
        pin_edges(1);
        check("R2 three toggles select SPI", 2'b10);
        pin_edges(6);
        check("R2 extra toggles keep SPI", 2'b10);
    endtask

    task automatic t_i2c_lock();
        do_reset();
        cfg_write(1'b0, 1'b0);
        check("R4 write lock=0 no lock", 2'b00);
        cfg_write(1'b1, 1'b0);
        check("R4 write lock=1 locks I2C", 2'b01);
        pin_edges(8);
        check("R5 toggles ignored when I2C locked", 2'b01);
        pwr_pulse();
        check("R8 I2C lock survives power change", 2'b01);
    endtask

    task automatic t_spi_lock();
        do_reset();
        pin_edges(6);
        check("R2 SPI before lock", 2'b10);
        cfg_write(1'b0, 1'b0);
        check("R6 any write locks SPI", 2'b11);
        pwr_pulse();
        check("R8 SPI lock survives power change", 2'b11);
        cfg_write(1'b1, 1'b0);
        pin_edges(6);
        check("R7 no return to I2C", 2'b11);
    endtask

    task automatic t_pwr_open();
        do_reset();
        pin_edges(6);
        pwr_pulse();
        check("R9 open SPI falls back to I2C", 2'b00);
        pin_edges(4);
        pwr_pulse();
        pin_edges(4);
        check("R9 partial count discarded", 2'b00);
        pin_edges(2);
        check("R9 fresh three toggles select SPI", 2'b10);
    endtask

    task automatic t_priority();
        do_reset();
        pin_edges(6);
        cfg_write(1'b0, 1'b1);
        check("R11 write beats power change in SPI", 2'b11);
        do_reset();
        cfg_write(1'b1, 1'b1);
        check("R11 write beats power change in I2C", 2'b01);
    endtask

    task automatic t_reset_clears();
        do_reset();
        pin_edges(6);
        cfg_write(1'b1, 1'b0);
        check("R10 locked before reset", 2'b11);
        do_reset();
        check("R10 reset clears lock", 2'b00);
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_toggle_switch();
        t_i2c_lock();
        t_spi_lock();
        t_pwr_open();
        t_priority();
        t_reset_clears();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule